// File: doc/BRIEF.md
# Programmable Panel Raster Timing Generator

This block produces the scan timing for a parallel RGB display panel. Eight length registers set the raster. Four of them give the horizontal pixel counts: visible, front porch, sync pulse and back porch. The other four give the same regions in whole lines for the vertical axis. From these the block drives a horizontal sync, a vertical sync and a data-enable strobe, together with the column and row of the visible pixel now on the bus. A start-of-frame pulse and an end-of-line pulse mark the raster for the logic that feeds pixels to the block.

Each of the three control outputs has its own polarity bit and its own disable bit. A disabled output stays at its idle level. Data enable and the coordinates can leave the block on either clock edge, and so can the two syncs. The sync edge either follows the data edge or is chosen on its own. The length registers are written through a small write port and are copied into a working set only at frame boundaries.

Sequencing uses a run controller with two states. `RS_IDLE` holds the raster at its origin and keeps all outputs idle. `RS_SCAN` advances the raster. The transition `RS_IDLE -> RS_SCAN` happens when `run_en` is sampled high, and `RS_SCAN -> RS_IDLE` happens when it is sampled low. Each axis has its own phase machine with four states: `PH_ACT -> PH_FRONT -> PH_SYNC -> PH_BACK -> PH_ACT`. A phase ends when its counter reaches the programmed length minus one. The horizontal machine steps on every scanning clock. The vertical machine steps when the horizontal machine leaves `PH_BACK`.

Top module: `panel_timing_gen`

## Requirements
- R1: Every line runs through the visible pixels, then the front porch, then the sync pulse, then the back porch. Each region lasts its programmed number of pixel clocks, and the line period is the sum of the four. The horizontal sync is asserted in the sync region of every line, including blanking lines.
- R2: Every frame runs through the visible lines, then the vertical front porch, then the vertical sync, then the vertical back porch. Each region lasts its programmed number of whole lines. The vertical sync is asserted for every pixel of its lines.
- R3: Data enable is asserted only when both axes are in their visible regions. While it is asserted, `col_o` and `row_o` give the pixel's position from 0. At all other times both read 0.
- R4: `pol_hs`, `pol_vs` and `pol_de` set the asserted level of their outputs. A value of 1 makes the asserted level high, and 0 makes it low. The idle level is the inverse.
- R5: When `off_hs`, `off_vs` or `off_de` is 1, that output stays at its idle level for the whole frame. The other outputs are not affected.
- R6: `de_edge` = 1 launches data enable and the coordinates on the rising clock edge. `de_edge` = 0 launches them on the following falling edge, half a cycle later.
- R7: When `sync_edge_en` = 1, `sync_edge` selects the launch edge of both syncs, with the same 0/1 meaning as in R6. When `sync_edge_en` = 0, the syncs use `de_edge`.
- R8: A length write made during a scan has no effect on the frame in progress. It takes effect from the first pixel of the next frame. While idle, the latest values are used by the next scan.
- R9: A write of 0 to any length register is ignored, and the register keeps its previous value.
- R10: After reset, and until scanning starts, every control output sits at its idle level and the coordinates, `sof_o` and `eol_o` are 0. The first pixel of a scan is visible pixel (0,0), launched at the second rising edge at which `run_en` is sampled high.
- R11: When `run_en` is sampled low, all outputs return to idle from the second rising edge on. A later scan starts again at pixel (0,0).
- R12: `sof_o` is high for exactly one cycle, with pixel (0,0) of every frame. `eol_o` is high for exactly one cycle, with the last pixel of every line. Both always launch on the rising edge.
- R13: The write port maps `cfg_addr` 0..3 to the horizontal visible, front porch, sync and back porch lengths, and 4..7 to the vertical ones in the same order. The value is taken from the low bits of `cfg_wdata` on a rising edge with `cfg_we` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Scan enable |
| cfg_we | input | 1 | Length register write strobe |
| cfg_addr | input | 3 | Length register select (R13) |
| cfg_wdata | input | CFG_W | Length value |
| pol_hs | input | 1 | Horizontal sync asserted level |
| pol_vs | input | 1 | Vertical sync asserted level |
| pol_de | input | 1 | Data enable asserted level |
| off_hs | input | 1 | Hold horizontal sync idle |
| off_vs | input | 1 | Hold vertical sync idle |
| off_de | input | 1 | Hold data enable idle |
| de_edge | input | 1 | Launch edge for data enable and coordinates |
| sync_edge_en | input | 1 | Use `sync_edge` for the syncs |
| sync_edge | input | 1 | Launch edge for the syncs |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| col_o | output | H_W | Visible column |
| row_o | output | V_W | Visible row |
| sof_o | output | 1 | Start-of-frame pulse |
| eol_o | output | 1 | End-of-line pulse |

## Verification
Raster pixel n of a scan is launched at rising edge n+1 after the edge that moves the controller into scanning. The falling-edge path shows the same value half a cycle later. A write is taken at its edge, but it reaches the raster only at the next frame boundary. Idle levels return two edges after `run_en` falls. The bench reads every raster value 3 ns after a rising edge, when both launch paths have settled. It tells the two edges apart by reading 1 ns after the edge, before the falling edge has come. Tallies of asserted cycles per frame are compared only after the full frame has been walked.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
    localparam int NUM_PHASES = 4;
    localparam int ADDR_W     = 3;

    typedef enum logic [1:0] {
        PH_ACT   = 2'd0,
        PH_FRONT = 2'd1,
        PH_SYNC  = 2'd2,
        PH_BACK  = 2'd3
    } ptg_phase_e;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_SCAN = 1'b1
    } ptg_run_e;
endpackage

// File: rtl/ptg_axis.sv
module ptg_axis
    import ptg_pkg::*;
#(
    parameter int W = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic                           step,
    input  logic [NUM_PHASES-1:0][W-1:0]   len,
    output logic [W-1:0]                   cnt,
    output logic                           active_o,
    output logic                           sync_o,
    output logic                           at_end_o
);
    ptg_phase_e phase_q, phase_n;
    logic [W-1:0] cnt_n;
    logic         phase_done;

    assign phase_done = (cnt >= (len[phase_q] - 1'b1));

    // next-state logic
    always_comb begin
        phase_n = phase_q;
        cnt_n   = cnt;
        if (clear) begin
            phase_n = PH_ACT;
            cnt_n   = '0;
        end else if (step) begin
            if (phase_done) begin
                cnt_n = '0;
                unique case (phase_q)
                    PH_ACT:   phase_n = PH_FRONT;
                    PH_FRONT: phase_n = PH_SYNC;
                    PH_SYNC:  phase_n = PH_BACK;
                    PH_BACK:  phase_n = PH_ACT;
                endcase
            end else begin
                cnt_n = cnt + 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_ACT;
            cnt     <= '0;
        end else begin
            phase_q <= phase_n;
            cnt     <= cnt_n;
        end
    end

    // outputs
    always_comb begin
        active_o = 1'b0;
        sync_o   = 1'b0;
        at_end_o = 1'b0;
        unique case (phase_q)
            PH_ACT:   active_o = 1'b1;
            PH_FRONT: ;
            PH_SYNC:  sync_o   = 1'b1;
            PH_BACK:  at_end_o = phase_done;
        endcase
    end
endmodule

// File: rtl/ptg_cfg_regs.sv
module ptg_cfg_regs
    import ptg_pkg::*;
#(
    parameter int H_W   = 12,
    parameter int V_W   = 11,
    parameter int CFG_W = 12,
    parameter logic [NUM_PHASES-1:0][H_W-1:0] H_RST = '1,
    parameter logic [NUM_PHASES-1:0][V_W-1:0] V_RST = '1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [CFG_W-1:0]                 wdata,
    input  logic                             load,
    output logic [NUM_PHASES-1:0][H_W-1:0]   live_h,
    output logic [NUM_PHASES-1:0][V_W-1:0]   live_v,
    output logic [NUM_PHASES-1:0][H_W-1:0]   work_h,
    output logic [NUM_PHASES-1:0][V_W-1:0]   work_v
);
    logic [H_W-1:0] wval_h;
    logic [V_W-1:0] wval_v;

    assign wval_h = wdata[H_W-1:0];
    assign wval_v = wdata[V_W-1:0];

    for (genvar i = 0; i < NUM_PHASES; i++) begin : g_len
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live_h[i] <= H_RST[i];
            end else if (we && (addr == ADDR_W'(i)) && (wval_h != '0)) begin
                live_h[i] <= wval_h;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live_v[i] <= V_RST[i];
            end else if (we && (addr == ADDR_W'(i + NUM_PHASES)) && (wval_v != '0)) begin
                live_v[i] <= wval_v;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_h <= H_RST;
            work_v <= V_RST;
        end else if (load) begin
            work_h <= live_h;
            work_v <= live_v;
        end
    end
endmodule

// File: rtl/ptg_launch.sv
module ptg_launch #(
    parameter int H_W = 12,
    parameter int V_W = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           de_nx,
    input  logic           hs_nx,
    input  logic           vs_nx,
    input  logic [H_W-1:0] col_nx,
    input  logic [V_W-1:0] row_nx,
    input  logic           sof_nx,
    input  logic           eol_nx,
    input  logic           data_rise,
    input  logic           sync_rise,
    input  logic [2:0]     pol,
    input  logic [2:0]     off,
    output logic           de_rise,
    output logic           hs_rise,
    output logic           vs_rise,
    output logic [H_W-1:0] col_rise,
    output logic [V_W-1:0] row_rise,
    output logic [2:0]     ctl_o,
    output logic [H_W-1:0] col_o,
    output logic [V_W-1:0] row_o,
    output logic           sof_o,
    output logic           eol_o
);
    logic           de_fall, hs_fall, vs_fall;
    logic [H_W-1:0] col_fall;
    logic [V_W-1:0] row_fall;
    logic [2:0]     ctl_l;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            de_rise  <= 1'b0;
            hs_rise  <= 1'b0;
            vs_rise  <= 1'b0;
            col_rise <= '0;
            row_rise <= '0;
            sof_o    <= 1'b0;
            eol_o    <= 1'b0;
        end else begin
            de_rise  <= de_nx;
            hs_rise  <= hs_nx;
            vs_rise  <= vs_nx;
            col_rise <= col_nx;
            row_rise <= row_nx;
            sof_o    <= sof_nx;
            eol_o    <= eol_nx;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            de_fall  <= 1'b0;
            hs_fall  <= 1'b0;
            vs_fall  <= 1'b0;
            col_fall <= '0;
            row_fall <= '0;
        end else begin
            de_fall  <= de_rise;
            hs_fall  <= hs_rise;
            vs_fall  <= vs_rise;
            col_fall <= col_rise;
            row_fall <= row_rise;
        end
    end

    // bit order of ctl: [2]=hsync, [1]=vsync, [0]=data enable
    assign ctl_l[2] = sync_rise ? hs_rise : hs_fall;
    assign ctl_l[1] = sync_rise ? vs_rise : vs_fall;
    assign ctl_l[0] = data_rise ? de_rise : de_fall;
    assign col_o    = data_rise ? col_rise : col_fall;
    assign row_o    = data_rise ? row_rise : row_fall;

    for (genvar i = 0; i < 3; i++) begin : g_level
        assign ctl_o[i] = (ctl_l[i] & ~off[i]) ~^ pol[i];
    end
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
    import ptg_pkg::*;
#(
    parameter int H_W         = 12,
    parameter int V_W         = 11,
    parameter int CFG_W       = 12,
    parameter int H_ACT_RST   = 640,
    parameter int H_FRONT_RST = 16,
    parameter int H_SYNC_RST  = 96,
    parameter int H_BACK_RST  = 48,
    parameter int V_ACT_RST   = 480,
    parameter int V_FRONT_RST = 10,
    parameter int V_SYNC_RST  = 2,
    parameter int V_BACK_RST  = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             pol_hs,
    input  logic             pol_vs,
    input  logic             pol_de,
    input  logic             off_hs,
    input  logic             off_vs,
    input  logic             off_de,
    input  logic             de_edge,
    input  logic             sync_edge_en,
    input  logic             sync_edge,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic [H_W-1:0]   col_o,
    output logic [V_W-1:0]   row_o,
    output logic             sof_o,
    output logic             eol_o
);
    localparam logic [NUM_PHASES-1:0][H_W-1:0] H_RST =
        {H_W'(H_BACK_RST), H_W'(H_SYNC_RST), H_W'(H_FRONT_RST), H_W'(H_ACT_RST)};
    localparam logic [NUM_PHASES-1:0][V_W-1:0] V_RST =
        {V_W'(V_BACK_RST), V_W'(V_SYNC_RST), V_W'(V_FRONT_RST), V_W'(V_ACT_RST)};

    ptg_run_e run_q, run_n;
    logic     scanning, h_end, v_end, frame_end, shadow_load;
    logic     h_act, h_sync, v_act, v_sync;
    logic [H_W-1:0] h_cnt;
    logic [V_W-1:0] v_cnt;
    logic [NUM_PHASES-1:0][H_W-1:0] live_h, work_h;
    logic [NUM_PHASES-1:0][V_W-1:0] live_v, work_v;
    logic           de_nx, hs_nx, vs_nx, sof_nx, eol_nx;
    logic [H_W-1:0] col_nx;
    logic [V_W-1:0] row_nx;
    logic           de_rise, hs_rise, vs_rise;
    logic [H_W-1:0] col_rise;
    logic [V_W-1:0] row_rise;
    logic [2:0]     ctl;

    // run controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= RS_IDLE;
        else        run_q <= run_n;
    end

    // run controller: transitions
    always_comb begin
        run_n = run_q;
        unique case (run_q)
            RS_IDLE: if (run_en)  run_n = RS_SCAN;
            RS_SCAN: if (!run_en) run_n = RS_IDLE;
        endcase
    end

    assign scanning    = (run_q == RS_SCAN);
    assign frame_end   = scanning && h_end && v_end;
    assign shadow_load = !scanning || frame_end;

    ptg_cfg_regs #(
        .H_W(H_W), .V_W(V_W), .CFG_W(CFG_W), .H_RST(H_RST), .V_RST(V_RST)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .load(shadow_load), .live_h(live_h), .live_v(live_v),
        .work_h(work_h), .work_v(work_v)
    );

    ptg_axis #(.W(H_W)) u_h_axis (
        .clk(clk), .rst_n(rst_n), .clear(!scanning), .step(scanning), .len(work_h),
        .cnt(h_cnt), .active_o(h_act), .sync_o(h_sync), .at_end_o(h_end)
    );

    ptg_axis #(.W(V_W)) u_v_axis (
        .clk(clk), .rst_n(rst_n), .clear(!scanning), .step(scanning && h_end),
        .len(work_v), .cnt(v_cnt), .active_o(v_act), .sync_o(v_sync), .at_end_o(v_end)
    );

    // raster values for the pixel the counters point at
    always_comb begin
        de_nx  = scanning && h_act && v_act;
        hs_nx  = scanning && h_sync;
        vs_nx  = scanning && v_sync;
        col_nx = de_nx ? h_cnt : '0;
        row_nx = de_nx ? v_cnt : '0;
        sof_nx = de_nx && (h_cnt == '0) && (v_cnt == '0);
        eol_nx = scanning && h_end;
    end

    ptg_launch #(.H_W(H_W), .V_W(V_W)) u_launch (
        .clk(clk), .rst_n(rst_n),
        .de_nx(de_nx), .hs_nx(hs_nx), .vs_nx(vs_nx), .col_nx(col_nx), .row_nx(row_nx),
        .sof_nx(sof_nx), .eol_nx(eol_nx),
        .data_rise(de_edge),
        .sync_rise(sync_edge_en ? sync_edge : de_edge),
        .pol({pol_hs, pol_vs, pol_de}), .off({off_hs, off_vs, off_de}),
        .de_rise(de_rise), .hs_rise(hs_rise), .vs_rise(vs_rise),
        .col_rise(col_rise), .row_rise(row_rise),
        .ctl_o(ctl), .col_o(col_o), .row_o(row_o), .sof_o(sof_o), .eol_o(eol_o)
    );

    assign hsync_o = ctl[2];
    assign vsync_o = ctl[1];
    assign de_o    = ctl[0];
endmodule

// File: rtl/ptg_checker.sv
module ptg_checker
    import ptg_pkg::*;
#(
    parameter int H_W = 12,
    parameter int V_W = 11
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           run_en,
    input logic                           sof_o,
    input logic                           eol_o,
    input logic                           de_rise,
    input logic                           hs_rise,
    input logic                           vs_rise,
    input logic [H_W-1:0]                 col_rise,
    input logic [V_W-1:0]                 row_rise,
    input logic                           shadow_load,
    input logic [NUM_PHASES-1:0][H_W-1:0] live_h,
    input logic [NUM_PHASES-1:0][V_W-1:0] live_v,
    input logic [NUM_PHASES-1:0][H_W-1:0] work_h,
    input logic [NUM_PHASES-1:0][V_W-1:0] work_v
);
    logic [1:0] idle_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               idle_cnt <= 2'd0;
        else if (run_en)          idle_cnt <= 2'd0;
        else if (idle_cnt != 2'd3) idle_cnt <= idle_cnt + 2'd1;
    end

    p_sof_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |=> !sof_o);

    p_eol_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        eol_o |=> !eol_o);

    p_sof_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |-> (de_rise && (col_rise == '0) && (row_rise == '0)));

    p_coord_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !de_rise |-> ((col_rise == '0) && (row_rise == '0)));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cnt >= 2'd2) |-> (!de_rise && !hs_rise && !vs_rise && !sof_o && !eol_o));

    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !shadow_load |=> ($stable(work_h) && $stable(work_v)));

    for (genvar i = 0; i < NUM_PHASES; i++) begin : g_nz
        p_live_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (live_h[i] != '0) && (live_v[i] != '0));
    end
endmodule

bind panel_timing_gen ptg_checker #(.H_W(H_W), .V_W(V_W)) u_ptg_checker (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .sof_o(sof_o), .eol_o(eol_o),
    .de_rise(de_rise), .hs_rise(hs_rise), .vs_rise(vs_rise),
    .col_rise(col_rise), .row_rise(row_rise), .shadow_load(shadow_load),
    .live_h(live_h), .live_v(live_v), .work_h(work_h), .work_v(work_v)
);

// File: tb/panel_timing_gen_tb_top.sv
module panel_timing_gen_tb_top;
    localparam int H_W   = 12;
    localparam int V_W   = 11;
    localparam int CFG_W = 12;

    typedef struct packed {
        logic [7:0]  ha, hf, hs, hb, va, vf, vs, vb;
        logic [2:0]  pol;   // {hs, vs, de}
        logic [2:0]  off;   // {hs, vs, de}
        logic        de_e, s_en, s_e;
        logic [15:0] exp_de, exp_hs, exp_vs;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{8'd4, 8'd1, 8'd2, 8'd1, 8'd3, 8'd1, 8'd1, 8'd1, 3'b111, 3'b000, 1'b1, 1'b0, 1'b0, 16'd12, 16'd12, 16'd8},
        '{8'd5, 8'd2, 8'd1, 8'd3, 8'd2, 8'd2, 8'd2, 8'd1, 3'b000, 3'b000, 1'b0, 1'b0, 1'b0, 16'd10, 16'd7,  16'd22},
        '{8'd3, 8'd3, 8'd3, 8'd3, 8'd4, 8'd1, 8'd3, 8'd2, 3'b101, 3'b100, 1'b1, 1'b1, 1'b0, 16'd12, 16'd0,  16'd36},
        '{8'd6, 8'd1, 8'd1, 8'd1, 8'd2, 8'd1, 8'd1, 8'd2, 3'b111, 3'b011, 1'b0, 1'b1, 1'b1, 16'd0,  16'd6,  16'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic pol_hs = 1'b1, pol_vs = 1'b1, pol_de = 1'b1;
    logic off_hs = 1'b0, off_vs = 1'b0, off_de = 1'b0;
    logic de_edge = 1'b1, sync_edge_en = 1'b0, sync_edge = 1'b0;
    logic hsync_o, vsync_o, de_o, sof_o, eol_o;
    logic [H_W-1:0] col_o;
    logic [V_W-1:0] row_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int cur_h [4];
    int cur_v [4];

    always #2 clk = ~clk;

    panel_timing_gen #(.H_W(H_W), .V_W(V_W), .CFG_W(CFG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .pol_hs(pol_hs), .pol_vs(pol_vs), .pol_de(pol_de),
        .off_hs(off_hs), .off_vs(off_vs), .off_de(off_de),
        .de_edge(de_edge), .sync_edge_en(sync_edge_en), .sync_edge(sync_edge),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .col_o(col_o), .row_o(row_o), .sof_o(sof_o), .eol_o(eol_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        cfg_addr  = 3'(addr);
        cfg_wdata = CFG_W'(data);
        cfg_we    = 1'b1;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    task automatic program_cur();
        for (int i = 0; i < 4; i++) wr(i, cur_h[i]);
        for (int i = 0; i < 4; i++) wr(i + 4, cur_v[i]);
    endtask

    task automatic start_run();
        run_en = 1'b1;
        @(posedge clk);
    endtask

    // R11: outputs idle from the second edge after run_en is seen low
    task automatic stop_run();
        run_en = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #3;
        chk({hsync_o, vsync_o, de_o, sof_o, eol_o} == {~pol_hs, ~pol_vs, ~pol_de, 2'b00},
            "R11", "idle levels after stop",
            {hsync_o, vsync_o, de_o, sof_o, eol_o}, {~pol_hs, ~pol_vs, ~pol_de, 2'b00});
        chk(col_o == '0 && row_o == '0, "R11", "coordinates after stop", {col_o, row_o}, 0);
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic run_frame(input string req, input int wr_at, input int wr_addr,
                             input int wr_data, output int n_de, output int n_hs,
                             output int n_vs);
        int htot, vtot;
        htot = cur_h[0] + cur_h[1] + cur_h[2] + cur_h[3];
        vtot = cur_v[0] + cur_v[1] + cur_v[2] + cur_v[3];
        n_de = 0; n_hs = 0; n_vs = 0;
        for (int n = 0; n < htot * vtot; n++) begin
            int x, y;
            bit a_de, a_hs, a_vs;
            logic [63:0] act, exp;
            @(posedge clk);
            #3;
            x = n % htot;
            y = n / htot;
            a_de = (x < cur_h[0]) && (y < cur_v[0]);
            a_hs = (x >= cur_h[0] + cur_h[1]) && (x < cur_h[0] + cur_h[1] + cur_h[2]);
            a_vs = (y >= cur_v[0] + cur_v[1]) && (y < cur_v[0] + cur_v[1] + cur_v[2]);
            exp = {(a_hs && !off_hs) ? pol_hs : ~pol_hs,
                   (a_vs && !off_vs) ? pol_vs : ~pol_vs,
                   (a_de && !off_de) ? pol_de : ~pol_de,
                   (x == 0 && y == 0), (x == htot - 1),
                   16'(a_de ? x : 0), 16'(a_de ? y : 0)};
            act = {hsync_o, vsync_o, de_o, sof_o, eol_o, 16'(col_o), 16'(row_o)};
            chk(act == exp, req, $sformatf("pixel %0d", n), act, exp);
            if (de_o == pol_de)    n_de++;
            if (hsync_o == pol_hs) n_hs++;
            if (vsync_o == pol_vs) n_vs++;
            if (n == wr_at) begin
                cfg_addr  = 3'(wr_addr);
                cfg_wdata = CFG_W'(wr_data);
                cfg_we    = 1'b1;
            end
            if (n == wr_at + 1) cfg_we = 1'b0;
        end
    endtask

    task automatic load_vec(input vec_t v);
        cur_h = '{int'(v.ha), int'(v.hf), int'(v.hs), int'(v.hb)};
        cur_v = '{int'(v.va), int'(v.vf), int'(v.vs), int'(v.vb)};
        {pol_hs, pol_vs, pol_de} = v.pol;
        {off_hs, off_vs, off_de} = v.off;
        de_edge      = v.de_e;
        sync_edge_en = v.s_en;
        sync_edge    = v.s_e;
    endtask

    // R6 / R7: look 1 ns after the edge, before the falling edge
    task automatic edge_probe(input bit de_e, input bit s_en, input bit s_e,
                              input bit de_early, input bit hs_early);
        de_edge = de_e; sync_edge_en = s_en; sync_edge = s_e;
        start_run();
        @(posedge clk);
        #1;
        chk(de_o == de_early, "R6", "data enable just after first rising edge", de_o, de_early);
        #2;
        chk(de_o == 1'b1, "R6", "data enable after falling edge", de_o, 1);
        repeat (5) @(posedge clk);
        #1;
        chk(hsync_o == hs_early, "R7", "hsync just after rising edge", hsync_o, hs_early);
        #2;
        chk(hsync_o == 1'b1, "R7", "hsync after falling edge", hsync_o, 1);
        stop_run();
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int nd, nh, nv;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #3;
        // R10: reset state, active-high polarities
        chk({hsync_o, vsync_o, de_o, sof_o, eol_o} == 5'b00000, "R10", "idle after reset",
            {hsync_o, vsync_o, de_o, sof_o, eol_o}, 0);
        chk(col_o == '0 && row_o == '0, "R10", "coordinates after reset", {col_o, row_o}, 0);
        // R4: idle level follows polarity
        {pol_hs, pol_vs, pol_de} = 3'b000;
        #1;
        chk({hsync_o, vsync_o, de_o} == 3'b111, "R4", "idle high with low polarity",
            {hsync_o, vsync_o, de_o}, 3'b111);
        @(posedge clk);
        #1;

        // table walk: R1 R2 R3 R4 R5 R12
        for (int k = 0; k < 4; k++) begin
            load_vec(VECS[k]);
            program_cur();
            start_run();
            run_frame("R1/R2/R3/R4/R5/R12", -5, 0, 0, nd, nh, nv);
            chk(nd == int'(VECS[k].exp_de), "R3/R5", $sformatf("vec %0d de count", k), nd, VECS[k].exp_de);
            chk(nh == int'(VECS[k].exp_hs), "R1/R5", $sformatf("vec %0d hsync count", k), nh, VECS[k].exp_hs);
            chk(nv == int'(VECS[k].exp_vs), "R2/R5", $sformatf("vec %0d vsync count", k), nv, VECS[k].exp_vs);
            stop_run();
        end

        // R9: zero writes ignored (addresses per R13)
        load_vec(VECS[0]);
        program_cur();
        wr(1, 0);
        wr(6, 0);
        start_run();
        run_frame("R9", -5, 0, 0, nd, nh, nv);
        stop_run();

        // R8: mid-frame write waits for next frame
        start_run();
        run_frame("R8 frame in progress", 10, 0, 6, nd, nh, nv);
        cur_h[0] = 6;
        run_frame("R8 following frame", -5, 0, 0, nd, nh, nv);
        chk(nd == 18, "R8", "visible pixels with new width", nd, 18);
        stop_run();

        // R11: stop mid-frame and restart at origin
        start_run();
        repeat (20) @(posedge clk);
        #1;
        stop_run();
        start_run();
        run_frame("R11 restart", -5, 0, 0, nd, nh, nv);
        stop_run();

        // R6 / R7 edge selection, V0 lengths restored
        cur_h[0] = 4;
        wr(0, 4);
        {pol_hs, pol_vs, pol_de} = 3'b111;
        {off_hs, off_vs, off_de} = 3'b000;
        edge_probe(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        edge_probe(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        edge_probe(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        edge_probe(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule